// File: doc/BRIEF.md
# Random Word Output Buffer Controller

This block sits between a pseudo-random word generator and the single software-visible output register of a random number unit. A generation step makes a 256-bit block available. Software drains that block one 32-bit word per read strobe. The controller counts how many words are still held and reports that count as a 3-bit quantity that never shows more than 4. When automatic mode is active it refills the buffer as soon as half of it has been drained. A read that cannot be served returns a fixed error word.

A write to the control register either regenerates the block or reseeds the generator, depending on the mode bit in that write. A dedicated bit in the same write performs a soft reset that only empties the buffer. A down-counting generation budget is loaded on every reseed. When the budget is already spent, the next regeneration is preceded by a forced reseed.

The generator is a small stub: a 32-bit maximal-length shift register. It steps once per consumed word and is loaded from a seed-hash input on every reseed.

Top module: `rand_word_buf`

## Requirements
- R1: After `rst_n` is deasserted, the block holds the following state: `qcnt`=0, `done`=0, `rd_ok`=0 and `rd_data`=0. The generator state is 1 and the generation budget is 0.
- R2: A regeneration sets the held-word count to 8. `qcnt` always equals the held count, saturated at 4, so it stays at 4 until fewer than 4 words remain.
- R3: A read is accepted when neither `blk_reset` nor `ctrl_soft_rst` is high and at least one word is held. On the next cycle, `rd_data` carries the generator word that was current before the read and `rd_ok`=1. The read consumes one word. The generator then steps as next = {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R4: A read strobe that is not accepted (because of reset, soft reset or an empty buffer) gives `rd_data`=32'h00000BAD and `rd_ok`=0 on the next cycle. Such a read consumes no word and does not step the generator.
- R5: Automatic refill happens when `single_gen`=0 and `ctrl_start`=1. In that case, an accepted read that leaves 3 or fewer words triggers a regeneration in the same cycle. The word returned by that read is taken before the refill.
- R6: A `ctrl_wr` with `ctrl_start`=1 and `ctrl_soft_rst`=0 acts according to `ctrl_regen`. With `ctrl_regen`=1 it regenerates. With `ctrl_regen`=0 it reseeds: the generator loads `seed_hash` (a zero seed loads 1), the buffer empties and the budget becomes 2^BUDGET_LOG2. Both cases set `done`. A `done_clr` pulse clears `done` unless a command sets it in the same cycle.
- R7: Each regeneration decrements the budget. When the budget is 0 at a regeneration, a reseed happens first: the generator reloads from `seed_hash` after the returned word is taken, and the budget becomes 2^BUDGET_LOG2-1.
- R8: While `blk_reset` is high, every `ctrl_wr` is ignored, the buffer is emptied and `done` is cleared.
- R9: A `ctrl_wr` with `ctrl_soft_rst`=1 empties the buffer and clears `done`. It neither regenerates nor reseeds, even when `ctrl_start`=1.
- R10: When a read and a control command fall in the same cycle, the read is served first, from the state before the command. The command's effect on the count and on the generator then overrides the effect of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read strobe on the output register |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_start | input | 1 | Start bit (level, also enables automatic refill) |
| ctrl_regen | input | 1 | Command mode: 1 regenerate, 0 reseed |
| ctrl_soft_rst | input | 1 | Soft-reset bit (level) |
| single_gen | input | 1 | Single-generation mode, disables automatic refill |
| blk_reset | input | 1 | Block held in reset |
| done_clr | input | 1 | Clears the done flag |
| seed_hash | input | 32 | Seed value loaded on reseed |
| rd_data | output | 32 | Word returned by the last read strobe |
| rd_ok | output | 1 | Last read strobe was accepted |
| qcnt | output | 3 | Held-word count saturated at 4 |
| done | output | 1 | Command-complete flag |

## Verification
Three functions can land in the same cycle: an accepted read, the automatic refill that this read triggers, and a forced reseed when the budget has run out. A control command can land in that cycle as well. The bench sets the budget to 8 so that it runs out within a few hundred cycles. It drives reads together with control writes at random, and also in directed cases where a read and a reseed command share one edge. A cycle-level reference model judges each case. The returned word must come from the generator state before the refill or reload. The count and the next word must follow the command.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] ERR_WORD = 32'h0000_0BAD;

  // one step of the maximal-length shift register (taps 32,22,2,1)
  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
    return {s[WORD_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // seed conditioning: the all-zero state is a lock-up state
  function automatic logic [WORD_W-1:0] seed_fix(input logic [WORD_W-1:0] v);
    return (v == '0) ? {{(WORD_W-1){1'b0}}, 1'b1} : v;
  endfunction

  // saturated quantity report
  function automatic logic [2:0] qcnt_sat(input int unsigned n, input int unsigned cap);
    return (n > cap) ? 3'(cap) : 3'(n);
  endfunction
endpackage

// File: rtl/rwb_lfsr.sv
module rwb_lfsr
  import rwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= {{(WORD_W-1){1'b0}}, 1'b1};
    else if (load) state <= seed_fix(load_val);
    else if (step) state <= lfsr_step(state);
  end

  assign word = state;
endmodule

// File: rtl/rwb_budget.sv
module rwb_budget #(
  parameter int BUD_W = 49
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             dec,
  output logic [BUD_W-1:0] level,
  output logic             empty
);
  localparam logic [BUD_W-1:0] FULL = {1'b1, {(BUD_W-1){1'b0}}};
  localparam logic [BUD_W-1:0] ONE  = {{(BUD_W-1){1'b0}}, 1'b1};

  assign empty = (level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (reload) level <= FULL;
    else if (dec)    level <= empty ? (FULL - ONE) : (level - ONE);
  end
endmodule

// File: rtl/rand_word_buf.sv
module rand_word_buf
  import rwb_pkg::*;
#(
  parameter int WORDS       = 8,
  parameter int QCNT_CAP    = 4,
  parameter int BUDGET_LOG2 = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        ctrl_wr,
  input  logic        ctrl_start,
  input  logic        ctrl_regen,
  input  logic        ctrl_soft_rst,
  input  logic        single_gen,
  input  logic        blk_reset,
  input  logic        done_clr,
  input  logic [31:0] seed_hash,
  output logic [31:0] rd_data,
  output logic        rd_ok,
  output logic [2:0]  qcnt,
  output logic        done
);
  localparam int CNT_W    = $clog2(WORDS + 1);
  localparam int BUD_W    = BUDGET_LOG2 + 1;
  localparam int LOW_MARK = WORDS / 2 - 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0] CNT_LOW  = CNT_W'(LOW_MARK);

  logic [CNT_W-1:0]  count;
  logic [BUD_W-1:0]  budget;
  logic              bud_empty;
  logic [WORD_W-1:0] gen_word;

  // named internal events
  logic rd_blocked, rd_accept, rd_reject, auto_regen;
  logic wr_ok, cmd_go, cmd_regen, cmd_reseed, cmd_srst;
  logic regen_any, forced_reseed, reseed_any;
  logic [CNT_W-1:0] cnt_after_rd;

  assign rd_blocked   = blk_reset | ctrl_soft_rst;
  assign rd_accept    = rd_req & ~rd_blocked & (count != '0);
  assign rd_reject    = rd_req & ~rd_accept;
  assign cnt_after_rd = count - CNT_W'(rd_accept);
  assign auto_regen   = rd_accept & ~single_gen & ctrl_start & (cnt_after_rd <= CNT_LOW);

  assign wr_ok      = ctrl_wr & ~blk_reset;
  assign cmd_srst   = wr_ok & ctrl_soft_rst;
  assign cmd_go     = wr_ok & ~ctrl_soft_rst & ctrl_start;
  assign cmd_regen  = cmd_go & ctrl_regen;
  assign cmd_reseed = cmd_go & ~ctrl_regen;

  assign regen_any     = (auto_regen | cmd_regen) & ~cmd_reseed;
  assign forced_reseed = regen_any & bud_empty;
  assign reseed_any    = cmd_reseed | forced_reseed;

  rwb_lfsr u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reseed_any),
    .load_val (seed_hash),
    .step     (rd_accept),
    .word     (gen_word)
  );

  rwb_budget #(.BUD_W(BUD_W)) u_bud (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (cmd_reseed),
    .dec    (regen_any),
    .level  (budget),
    .empty  (bud_empty)
  );

  // held-word count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (blk_reset || cmd_srst)  count <= '0;
    else if (cmd_reseed)             count <= '0;
    else if (regen_any)              count <= CNT_FULL;
    else                             count <= cnt_after_rd;
  end

  // command-complete flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      done <= 1'b0;
    else if (blk_reset || cmd_srst)  done <= 1'b0;
    else if (cmd_go)                 done <= 1'b1;
    else if (done_clr)               done <= 1'b0;
  end

  // read return path: word captured before any reload or refill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ok   <= 1'b0;
    end else begin
      rd_ok <= rd_accept;
      if (rd_accept)      rd_data <= gen_word;
      else if (rd_reject) rd_data <= ERR_WORD;
    end
  end

  assign qcnt = qcnt_sat(int'(count), QCNT_CAP);
endmodule

// File: rtl/rand_word_buf_chk.sv
module rand_word_buf_chk #(
  parameter int CNT_W = 4,
  parameter int BUD_W = 49,
  parameter int CAP   = 4,
  parameter int WORDS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             blk_reset,
  input logic             ctrl_soft_rst,
  input logic             rd_ok,
  input logic [31:0]      rd_data,
  input logic [2:0]       qcnt,
  input logic             done,
  input logic [CNT_W-1:0] count,
  input logic [BUD_W-1:0] budget,
  input logic             rd_accept,
  input logic             regen_any,
  input logic             cmd_reseed,
  input logic             cmd_srst,
  input logic             cmd_go
);
  // R2
  qcnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt <= 3'(CAP)) && (int'(count) <= WORDS));

  // R2
  refill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regen_any && !blk_reset && !cmd_srst) |=> (int'(count) == WORDS));

  // R3
  read_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> rd_ok);

  // R4
  read_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (blk_reset || ctrl_soft_rst)) |=> (!rd_ok && rd_data == 32'h0000_0BAD));

  // R6
  cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> done);

  // R6
  reseed_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reseed && !blk_reset) |=> (count == '0));

  // R7
  budget_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regen_any && !cmd_reseed && budget != '0) |=> (budget == $past(budget) - 1'b1));

  // R8
  blk_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_reset |=> (count == '0 && !done));

  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_srst |=> (count == '0 && !done && $stable(budget)));
endmodule

bind rand_word_buf rand_word_buf_chk #(
  .CNT_W(CNT_W), .BUD_W(BUD_W), .CAP(QCNT_CAP), .WORDS(WORDS)
) u_chk (.*);

// File: tb/rand_word_buf_test.sv
`timescale 1ns/1ps
module rand_word_buf_test;
  localparam int BLOG = 3;
  localparam int BFULL = 1 << BLOG;
  localparam logic [31:0] BAD = 32'h0000_0BAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 0, ctrl_wr = 0, ctrl_start = 0, ctrl_regen = 0, ctrl_soft_rst = 0;
  logic single_gen = 0, blk_reset = 0, done_clr = 0;
  logic [31:0] seed_hash = '0;
  logic [31:0] rd_data;
  logic rd_ok, done;
  logic [2:0] qcnt;

  int n_chk = 0, n_bad = 0;

  // reference model state
  int m_cnt, m_bud;
  logic [31:0] m_gen, e_data;
  logic e_ok, e_done;

  always #2 clk = ~clk;

  rand_word_buf #(.BUDGET_LOG2(BLOG)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .ctrl_wr(ctrl_wr),
    .ctrl_start(ctrl_start), .ctrl_regen(ctrl_regen), .ctrl_soft_rst(ctrl_soft_rst),
    .single_gen(single_gen), .blk_reset(blk_reset), .done_clr(done_clr),
    .seed_hash(seed_hash), .rd_data(rd_data), .rd_ok(rd_ok), .qcnt(qcnt), .done(done)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic fb;
    fb = ^(s & 32'h8020_0003);
    return (s << 1) | {31'd0, fb};
  endfunction

  function automatic logic [31:0] ld(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

  function automatic int sat(input int n);
    return (n < 4) ? n : 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // predict the state after the next edge from the current inputs
  task automatic model_step();
    bit acc, aut, wok, srs, go, cres, rany;
    int c1;
    logic [31:0] g1;
    acc = rd_req && !blk_reset && !ctrl_soft_rst && m_cnt != 0;
    if (rd_req) begin e_data = acc ? m_gen : BAD; end
    e_ok = acc;
    c1 = m_cnt - (acc ? 1 : 0);
    g1 = acc ? nxt(m_gen) : m_gen;
    aut = acc && !single_gen && ctrl_start && c1 <= 3;
    wok = ctrl_wr && !blk_reset;
    srs = wok && ctrl_soft_rst;
    go = wok && !ctrl_soft_rst && ctrl_start;
    cres = go && !ctrl_regen;
    rany = (aut || (go && ctrl_regen)) && !cres;
    if (cres) begin
      m_cnt = 0; m_gen = ld(seed_hash); m_bud = BFULL;
    end else if (rany) begin
      m_cnt = 8;
      if (m_bud == 0) begin m_gen = ld(seed_hash); m_bud = BFULL - 1; end
      else begin m_gen = g1; m_bud--; end
    end else begin
      m_cnt = c1; m_gen = g1;
    end
    if (blk_reset || srs) begin m_cnt = 0; e_done = 0; end
    else if (go) e_done = 1;
    else if (done_clr) e_done = 0;
  endtask

  // apply current inputs for one edge, then compare all outputs
  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R3 rd_data", rd_data, e_data);
    chk("R4 rd_ok", {31'd0, rd_ok}, {31'd0, e_ok});
    chk("R2 qcnt", {29'd0, qcnt}, 32'(sat(m_cnt)));
    chk("R6 done", {31'd0, done}, {31'd0, e_done});
  endtask

  task automatic idle();
    rd_req = 0; ctrl_wr = 0; done_clr = 0; blk_reset = 0; ctrl_soft_rst = 0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_cnt = 0; m_bud = 0; m_gen = 32'd1; e_data = '0; e_ok = 0; e_done = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 qcnt", {29'd0, qcnt}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 rd_ok", {31'd0, rd_ok}, 32'd0);

    // R4 read on empty buffer
    rd_req = 1; cycle(); idle();
    chk("R4 empty read", rd_data, BAD);

    // R6 regen command, R7 forced reseed from spent budget
    single_gen = 1; seed_hash = 32'h1234_5678;
    ctrl_wr = 1; ctrl_start = 1; ctrl_regen = 1; cycle(); idle();
    chk("R6 done set", {31'd0, done}, 32'd1);
    chk("R2 qcnt full", {29'd0, qcnt}, 32'd4);
    rd_req = 1; cycle();
    chk("R7 forced reseed word", rd_data, 32'h1234_5678);
    repeat (4) cycle();
    chk("R2 qcnt below cap", {29'd0, qcnt}, 32'd3);
    idle();

    // R5 automatic refill: this read leaves 2
    single_gen = 0; rd_req = 1; cycle(); idle();
    chk("R5 auto refill", {29'd0, qcnt}, 32'd4);

    // R10 read plus reseed command in one cycle, zero seed loads 1
    seed_hash = 32'd0; rd_req = 1; ctrl_wr = 1; ctrl_regen = 0; cycle(); idle();
    chk("R10 read served", {31'd0, rd_ok}, 32'd1);
    chk("R10 reseed empties", {29'd0, qcnt}, 32'd0);
    ctrl_wr = 1; ctrl_regen = 1; cycle(); idle();
    rd_req = 1; cycle(); idle();
    chk("R6 zero seed", rd_data, 32'd1);

    // R8 write ignored in block reset
    blk_reset = 1; ctrl_wr = 1; cycle(); idle();
    chk("R8 cleared", {29'd0, qcnt}, 32'd0);
    chk("R8 no done", {31'd0, done}, 32'd0);
    ctrl_wr = 1; ctrl_regen = 1; cycle(); idle();

    // R9 soft reset write with start set
    ctrl_wr = 1; ctrl_soft_rst = 1; cycle(); idle();
    chk("R9 soft empty", {29'd0, qcnt}, 32'd0);
    chk("R9 soft done", {31'd0, done}, 32'd0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      rd_req        = ($urandom % 100) < 60;
      ctrl_wr       = ($urandom % 100) < 6;
      ctrl_start    = ($urandom % 100) < 75;
      ctrl_regen    = ($urandom % 100) < 70;
      ctrl_soft_rst = ($urandom % 100) < 3;
      single_gen    = ($urandom % 100) < 25;
      blk_reset     = ($urandom % 100) < 2;
      done_clr      = ($urandom % 100) < 5;
      seed_hash     = (($urandom % 8) == 0) ? 32'd0 : $urandom;
      cycle();
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule